// File: doc/BRIEF.md
# Random Generator Register Controller

This block sits between the conditioning stage of a true random number generator and the register bus. It takes 128-bit conditioned results over a valid/ready handshake and holds up to two of them. Software reads each result as four 32-bit words from a single data register, with the least significant word first. The block also holds the control settings: generator enable, interrupt enable, a request that resets the conditioning path, a configuration lock, and a clock-divider setting for the upstream stage. Status bits report data ready, a seed error and a clock error. The interrupt output is a level.

A conditioning soft reset takes two writes to the control register. The first write sets the reset bit and leaves enable at 0. This empties both result buffers. The second write clears the reset bit and sets enable. A divider value written with the reset request reaches the upstream stage only on the restart write. Once the lock bit is set, only a hardware reset clears it. While it is set, the divider setting is frozen.

Register map by `reg_addr`: 0 is control, 1 is status, 2 is data. Address 3 reads as zero. Reads return data on `reg_rdata` in the same cycle. A read strobe on the data register uses up one word at the next clock edge.

Top module: `trng_regctl`

## Requirements
- R1: After hardware reset, the control register reads 0 (enable, interrupt enable, reset request, lock and divider all 0) and the status register reads 0. `irq`, `up_ready` and `clkdiv_o` are 0.
- R2: `up_ready` is 1 only when all of these hold: enable (control bit 0) is 1, the reset request (control bit 2) is 0, neither error flag is set, and fewer than two results are held. A result is taken on a clock edge where both `up_valid` and `up_ready` are 1.
- R3: A held result is read as four data-register reads, returning bits [31:0], [63:32], [95:64] and [127:96] in that order. Data ready (status bit 0) is 1 while a result is held, and the fourth read frees that result.
- R4: When a second result is held, data ready stays 1 after the fourth read. The next four reads return the second result, so results come out in arrival order.
- R5: A data-register read while data ready is 0 returns 0 and leaves the word position and the buffers unchanged.
- R6: A control write with the reset request at 1 empties both buffers. Data ready and `up_ready` then stay 0 until a control write with enable at 1 and the reset request at 0.
- R7: The divider field (control bits 7:4) is stored when written. `clkdiv_o` takes the stored value only on a control write that clears a pending reset request.
- R8: Writing 1 to the lock bit (control bit 3) sets it. A write of 0 does not clear it. While the lock bit is set, writes to the divider field are ignored, including writes that go with a reset request.
- R9: A pulse on `seed_err_i` sets status bit 1, and a pulse on `clk_err_i` sets status bit 2. Writing 0 to a flag bit in the status register clears it; writing 1 leaves it set. While either flag is set, data ready reads 0 and data reads return 0. The word position is kept.
- R10: `irq` is 1 exactly when interrupt enable (control bit 1) is 1 and data ready or either error flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of the data register uses up one word) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read |
| up_valid | input | 1 | Upstream result valid |
| up_data | input | 128 | Upstream conditioned result |
| up_ready | output | 1 | Block can take a result |
| seed_err_i | input | 1 | Seed error pulse |
| clk_err_i | input | 1 | Clock error pulse |
| irq | output | 1 | Level interrupt |
| gen_run | output | 1 | Generation active, sent to the upstream stage |
| clkdiv_o | output | 4 | Divider setting applied upstream |

## Verification
A word index that is out of step shows up on the first data read that follows: the data comes back rotated within the 128-bit result. A slot that is freed at the wrong time shows up as a data ready bit that is wrong right after a fourth read. A flush that is missing or incomplete leaves data ready at 1, or leaves old words readable, as soon as the reset request is written. Lock and divider faults show up on the next control readback, or on `clkdiv_o` in the cycle after the restart write.

// File: rtl/trng_pkg.sv
package trng_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN      = 0;
  localparam int CTRL_IE      = 1;
  localparam int CTRL_CRST    = 2;
  localparam int CTRL_LOCK    = 3;
  localparam int CTRL_DIV_LSB = 4;

  localparam int STAT_RDY  = 0;
  localparam int STAT_SEED = 1;
  localparam int STAT_CLK  = 2;
endpackage

// File: rtl/trng_ctrl_regs.sv
module trng_ctrl_regs
  import trng_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wdata,
  input  logic             seed_pulse,
  input  logic             clk_pulse,
  output logic             en_o,
  output logic             ie_o,
  output logic             crst_o,
  output logic             lock_o,
  output logic [DIV_W-1:0] div_cfg_o,
  output logic [DIV_W-1:0] div_act_o,
  output logic             seed_flag_o,
  output logic             clk_flag_o
);
  logic             en_q, ie_q, crst_q, lock_q, seed_q, clkf_q;
  logic [DIV_W-1:0] div_q, act_q;

  // named internal events
  logic             wr_ctrl, wr_stat, restart_evt;
  logic             seed_clr, clk_clr;
  logic [DIV_W-1:0] div_next;

  assign wr_ctrl     = wr_en && (wr_addr == A_CTRL);
  assign wr_stat     = wr_en && (wr_addr == A_STAT);
  assign restart_evt = wr_ctrl && crst_q && !wdata[CTRL_CRST];
  assign seed_clr    = wr_stat && !wdata[STAT_SEED];
  assign clk_clr     = wr_stat && !wdata[STAT_CLK];
  assign div_next    = lock_q ? div_q : wdata[CTRL_DIV_LSB +: DIV_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      crst_q <= 1'b0;
      lock_q <= 1'b0;
      div_q  <= '0;
      act_q  <= '0;
      seed_q <= 1'b0;
      clkf_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata[CTRL_EN];
        ie_q   <= wdata[CTRL_IE];
        crst_q <= wdata[CTRL_CRST];
        lock_q <= lock_q | wdata[CTRL_LOCK];
        div_q  <= div_next;
      end
      if (restart_evt) act_q <= div_next;
      seed_q <= seed_pulse | (seed_q & !seed_clr);
      clkf_q <= clk_pulse  | (clkf_q & !clk_clr);
    end
  end

  assign en_o        = en_q;
  assign ie_o        = ie_q;
  assign crst_o      = crst_q;
  assign lock_o      = lock_q;
  assign div_cfg_o   = div_q;
  assign div_act_o   = act_q;
  assign seed_flag_o = seed_q;
  assign clk_flag_o  = clkf_q;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(div_q)); // R8
  AST_DIV_AT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_evt |=> $stable(act_q)); // R7
  AST_SEED_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    seed_pulse |=> seed_q); // R9
  AST_CLK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_pulse |=> clkf_q); // R9
endmodule

// File: rtl/trng_outbuf.sv
module trng_outbuf #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     accept_ok,
  input  logic                     in_valid,
  input  logic [WORD_W*WORDS-1:0]  in_data,
  output logic                     in_ready,
  input  logic                     rd_word,
  output logic [WORD_W-1:0]        word_o,
  output logic                     has_data
);
  localparam int BLK_W = WORD_W * WORDS;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS - 1);

  function automatic logic [WORD_W-1:0] word_of(input logic [BLK_W-1:0] blk,
                                                 input logic [IDX_W-1:0] idx);
    return blk[idx*WORD_W +: WORD_W];
  endfunction

  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] idx);
    return (idx == IDX_LAST) ? '0 : idx + 1'b1;
  endfunction

  logic [BLK_W-1:0] slot_q [2];
  logic [1:0]       full_q;
  logic             wr_sel_q, rd_sel_q;
  logic [IDX_W-1:0] idx_q;

  // named internal events
  logic push_evt, pop_evt, last_word, free_evt;

  assign in_ready  = accept_ok && !full_q[wr_sel_q];
  assign push_evt  = in_valid && in_ready;
  assign has_data  = full_q[rd_sel_q];
  assign pop_evt   = rd_word && has_data;
  assign last_word = (idx_q == IDX_LAST);
  assign free_evt  = pop_evt && last_word;
  assign word_o    = word_of(slot_q[rd_sel_q], idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) slot_q[i] <= '0;
      full_q   <= '0;
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      idx_q    <= '0;
    end else if (flush) begin
      for (int i = 0; i < 2; i++) slot_q[i] <= '0;
      full_q   <= '0;
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      if (push_evt) begin
        slot_q[wr_sel_q] <= in_data;
        full_q[wr_sel_q] <= 1'b1;
        wr_sel_q         <= !wr_sel_q;
      end
      if (pop_evt) begin
        idx_q <= idx_step(idx_q);
        if (last_word) begin
          full_q[rd_sel_q] <= 1'b0;
          rd_sel_q         <= !rd_sel_q;
        end
      end
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (full_q == 2'b00) && (idx_q == '0)); // R6
  AST_IDLE_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word && !has_data && !flush) |=> $stable(idx_q) && $stable(rd_sel_q)); // R5
  AST_SECOND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (free_evt && !flush && full_q[!rd_sel_q]) |=> has_data); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q == 2'b11) |-> !in_ready); // R2
endmodule

// File: rtl/trng_rd_mux.sv
module trng_rd_mux
  import trng_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DIV_W = 4
) (
  input  logic [1:0]       addr,
  input  logic             en,
  input  logic             ie,
  input  logic             crst,
  input  logic             lock,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             drdy,
  input  logic             seed_flag,
  input  logic             clk_flag,
  input  logic [DW-1:0]    word,
  output logic [DW-1:0]    rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: begin
        rdata[CTRL_EN]                  = en;
        rdata[CTRL_IE]                  = ie;
        rdata[CTRL_CRST]                = crst;
        rdata[CTRL_LOCK]                = lock;
        rdata[CTRL_DIV_LSB +: DIV_W]    = div_cfg;
      end
      A_STAT: begin
        rdata[STAT_RDY]  = drdy;
        rdata[STAT_SEED] = seed_flag;
        rdata[STAT_CLK]  = clk_flag;
      end
      A_DATA:  rdata = drdy ? word : '0;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/trng_regctl.sv
module trng_regctl
  import trng_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int DIV_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [1:0]              reg_addr,
  input  logic [WORD_W-1:0]       reg_wdata,
  output logic [WORD_W-1:0]       reg_rdata,
  input  logic                    up_valid,
  input  logic [WORD_W*WORDS-1:0] up_data,
  output logic                    up_ready,
  input  logic                    seed_err_i,
  input  logic                    clk_err_i,
  output logic                    irq,
  output logic                    gen_run,
  output logic [DIV_W-1:0]        clkdiv_o
);
  logic             en, ie, crst, lock, seed_flag, clk_flag;
  logic [DIV_W-1:0] div_cfg;
  logic             has_data, drdy, any_err, data_rd;
  logic [WORD_W-1:0] word;

  trng_ctrl_regs #(.DW(WORD_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wdata(reg_wdata), .seed_pulse(seed_err_i), .clk_pulse(clk_err_i),
    .en_o(en), .ie_o(ie), .crst_o(crst), .lock_o(lock),
    .div_cfg_o(div_cfg), .div_act_o(clkdiv_o),
    .seed_flag_o(seed_flag), .clk_flag_o(clk_flag)
  );

  assign any_err = seed_flag || clk_flag;
  assign gen_run = en && !crst && !any_err;
  assign drdy    = has_data && !any_err;
  assign data_rd = reg_rd && (reg_addr == A_DATA) && drdy;
  assign irq     = ie && (drdy || any_err);

  trng_outbuf #(.WORD_W(WORD_W), .WORDS(WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(crst), .accept_ok(gen_run),
    .in_valid(up_valid), .in_data(up_data), .in_ready(up_ready),
    .rd_word(data_rd), .word_o(word), .has_data(has_data)
  );

  trng_rd_mux #(.DW(WORD_W), .DIV_W(DIV_W)) u_mux (
    .addr(reg_addr), .en(en), .ie(ie), .crst(crst), .lock(lock),
    .div_cfg(div_cfg), .drdy(drdy), .seed_flag(seed_flag),
    .clk_flag(clk_flag), .word(word), .rdata(reg_rdata)
  );

  AST_NO_ACCEPT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready |-> !seed_flag && !clk_flag && !crst); // R2
  AST_CRST_HIDES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $past(crst) && crst |-> !drdy); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie); // R10
endmodule

// File: tb/trng_regctl_tb_top.sv
module trng_regctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         up_valid = 1'b0;
  logic [127:0] up_data = '0;
  logic         up_ready;
  logic         seed_err_i = 1'b0, clk_err_i = 1'b0;
  logic         irq, gen_run;
  logic [3:0]   clkdiv_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [127:0] VEC [4] = '{
    128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
    128'hdead_beef_0000_ffff_a5a5_5a5a_1357_9bdf,
    128'h8000_0001_4000_0002_2000_0004_1000_0008,
    128'hcafe_f00d_0bad_c0de_1111_2222_3333_4444
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  trng_regctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
    .seed_err_i(seed_err_i), .clk_err_i(clk_err_i), .irq(irq),
    .gen_run(gen_run), .clkdiv_o(clkdiv_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, {96'd0, v}, {96'd0, exp});
  endtask

  task automatic push(input logic [127:0] d);
    @(negedge clk);
    up_valid = 1'b1; up_data = d;
    while (!up_ready) @(negedge clk);
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic read_block(input string req, input logic [127:0] blk, input int first);
    for (int w = first; w < 4; w++) rd_chk(req, 2'd2, blk[w*32 +: 32]);
  endtask

  task automatic pulse_err(input bit seed);
    @(negedge clk);
    if (seed) seed_err_i = 1'b1; else clk_err_i = 1'b1;
    @(negedge clk);
    seed_err_i = 1'b0; clk_err_i = 1'b0;
  endtask

  task automatic port_chk(input string req, input logic act, input logic exp);
    @(negedge clk);
    chk(req, {127'd0, act}, {127'd0, exp});
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 ctrl", 2'd0, 32'h0);
    rd_chk("R1 stat", 2'd1, 32'h0);
    port_chk("R1 irq", irq, 1'b0);
    port_chk("R1 up_ready", up_ready, 1'b0);
    chk("R1 clkdiv", {124'd0, clkdiv_o}, 128'd0);

    wr(2'd0, 32'h3);
    port_chk("R2 ready when enabled", up_ready, 1'b1);
    port_chk("R10 irq idle", irq, 1'b0);

    // table walk: R3 word order
    for (int i = 0; i < 4; i++) begin
      push(VEC[i]);
      rd_chk("R3 ready set", 2'd1, 32'h1);
      port_chk("R10 irq on data", irq, 1'b1);
      read_block("R3 word", VEC[i], 0);
      rd_chk("R3 freed", 2'd1, 32'h0);
    end

    // R4 two-deep
    push(VEC[0]);
    push(VEC[1]);
    port_chk("R2 full blocks", up_ready, 1'b0);
    read_block("R4 first", VEC[0], 0);
    rd_chk("R4 ready stays", 2'd1, 32'h1);
    read_block("R4 second", VEC[1], 0);
    rd_chk("R4 drained", 2'd1, 32'h0);

    // R5 idle read
    rd_chk("R5 idle zero", 2'd2, 32'h0);
    push(VEC[2]);
    rd_chk("R5 index kept", 2'd2, VEC[2][31:0]);
    read_block("R3 rest", VEC[2], 1);

    // R9 errors
    push(VEC[3]);
    pulse_err(1'b1);
    rd_chk("R9 seed flag", 2'd1, 32'h2);
    rd_chk("R9 data gated", 2'd2, 32'h0);
    port_chk("R2 blocked on error", up_ready, 1'b0);
    port_chk("R10 irq on error", irq, 1'b1);
    wr(2'd1, 32'h2);
    rd_chk("R9 write1 keeps", 2'd1, 32'h2);
    wr(2'd1, 32'h0);
    rd_chk("R9 cleared", 2'd1, 32'h1);
    pulse_err(1'b0);
    rd_chk("R9 clk flag", 2'd1, 32'h4);
    wr(2'd1, 32'h0);
    rd_chk("R9 index held", 2'd2, VEC[3][31:0]);
    read_block("R3 rest", VEC[3], 1);

    // R6 / R7 soft reset
    push(VEC[1]);
    wr(2'd0, 32'h56);
    rd_chk("R6 flushed", 2'd1, 32'h0);
    port_chk("R6 no accept", up_ready, 1'b0);
    chk("R7 div pending", {124'd0, clkdiv_o}, 128'd0);
    rd_chk("R7 ctrl readback", 2'd0, 32'h56);
    wr(2'd0, 32'h53);
    chk("R7 div applied", {124'd0, clkdiv_o}, 128'd5);
    port_chk("R6 accept resumes", up_ready, 1'b1);
    rd_chk("R6 no stale data", 2'd1, 32'h0);
    wr(2'd0, 32'h73);
    chk("R7 no restart", {124'd0, clkdiv_o}, 128'd5);

    // R8 lock
    wr(2'd0, 32'h7B);
    wr(2'd0, 32'h93);
    rd_chk("R8 locked", 2'd0, 32'h7B);
    wr(2'd0, 32'h96);
    rd_chk("R8 locked crst", 2'd0, 32'h7E);
    wr(2'd0, 32'h93);
    chk("R8 div kept", {124'd0, clkdiv_o}, 128'd7);

    // R10 irq masked
    push(VEC[0]);
    wr(2'd0, 32'h01);
    port_chk("R10 masked", irq, 1'b0);
    rd_chk("R10 data present", 2'd1, 32'h1);
    rd_chk("R8 lock sticks", 2'd0, 32'h79);

    // R1 hard reset clears lock
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R1 lock cleared", 2'd0, 32'h0);
    rd_chk("R1 stat cleared", 2'd1, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule